// File: doc/BRIEF.md
# Switch Port-Group Forwarding Mask Resolver

This block produces the egress port mask for one Layer-2 frame. It keeps a table of port bitmasks, one bit per physical port plus one bit for the CPU port. Each frame triggers three reads of this table: a destination entry, an aggregation entry and a source-port entry. The bitwise AND of the three entries is the forwarding mask. Configuration software fills the table through a single-entry write port.

When the address lookup finds the destination, the index supplied with that result selects the destination entry. When the lookup misses, the frame class selects a flood entry. The aggregation entry reduces a link aggregation group to one member port. The source entry sets which egress ports the ingress port may reach. The lookup runs as a two-stage pipeline with no backpressure: stage 1 registers the three indices, and stage 2 registers the masked result.

Top module: `pgmask_resolver`

## Requirements
- R1: After reset every table entry reads as zero, so any frame handled before configuration gets an all-zero mask.
- R2: A frame presented with `req_valid` high in cycle t gives `rsp_valid` high in cycle t+2, with its result. The output stream keeps the input order, and `rsp_valid` never rises without a matching request two cycles earlier.
- R3: The forwarding mask equals entry[D] AND entry[64+agg_code] AND entry[80+src_port]. Masks are NPORTS+1 bits wide, and bit NPORTS is the CPU port.
- R4: On a lookup hit (`req_hit`=1), D equals `req_dst_idx` (0..63). Index 59 is used this way for CPU-bound addresses and gets no special handling.
- R5: On a miss, D depends on the frame class. Class 0 (unknown unicast) uses 60, class 1 (broadcast) and class 2 (non-IP multicast) use 61, class 3 (IPv4 multicast) uses 62, and class 4 (IPv6 multicast) uses 63. On a miss, `req_dst_idx` has no effect.
- R6: The aggregation entry index is 64 plus the 4-bit aggregation code, so it spans 64..79.
- R7: The source entry index is 80 plus `req_src_port`. If `req_src_port` >= NPORTS, the mask is all-zero and `rsp_err` is high together with `rsp_valid`. `rsp_err` is low otherwise.
- R8: A write with `cfg_we` high stores `cfg_data` into entry `cfg_idx` at the clock edge. A frame whose read stage takes place in the same cycle still sees the previous contents. A write to an index >= 80+NPORTS has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Table write strobe |
| cfg_idx | input | 7 | Entry index to write |
| cfg_data | input | NPORTS+1 | Mask value to write |
| req_valid | input | 1 | Frame request valid |
| req_hit | input | 1 | Address lookup hit |
| req_dst_idx | input | 6 | Destination entry index on a hit |
| req_class | input | 3 | Frame class code (0..4) |
| req_agg_code | input | 4 | Link aggregation code |
| req_src_port | input | 4 | Ingress port number |
| rsp_valid | output | 1 | Result valid |
| rsp_mask | output | NPORTS+1 | Forwarding mask |
| rsp_err | output | 1 | Ingress port out of range |

## Verification
Assertions check every cycle that the two-cycle valid latency holds, that the stage-1 indices stay inside their table regions, that an error result always carries a zero mask, and that `rsp_err` never appears without `rsp_valid`. Only the bench scenarios can show that the right entries are selected and ANDed: the flood mapping per class, the CPU bit position, out-of-range writes being dropped, and a same-cycle write that returns the old value. The bench checks these against a table model of its own.

// File: rtl/pgmask_pkg.sv
package pgmask_pkg;
    localparam int IDX_W    = 7;
    localparam int DST_W    = 6;
    localparam int AGG_BASE = 64;
    localparam int SRC_BASE = 80;
    localparam int FLOOD_UC   = 60;
    localparam int FLOOD_MC   = 61;
    localparam int FLOOD_IPV4 = 62;
    localparam int FLOOD_IPV6 = 63;

    typedef enum logic [2:0] {
        CLS_UCAST = 3'd0,
        CLS_BCAST = 3'd1,
        CLS_MCAST = 3'd2,
        CLS_IPV4  = 3'd3,
        CLS_IPV6  = 3'd4
    } frame_class_e;

    typedef struct packed {
        logic             valid;
        logic             err;
        logic [IDX_W-1:0] dst;
        logic [IDX_W-1:0] agg;
        logic [IDX_W-1:0] src;
    } idx_stage_t;
endpackage

// File: rtl/pgmask_index_sel.sv
module pgmask_index_sel
    import pgmask_pkg::*;
#(
    parameter int NPORTS = 11,
    parameter int PORT_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              in_hit,
    input  logic [DST_W-1:0]  in_dst_idx,
    input  logic [2:0]        in_class,
    input  logic [3:0]        in_agg_code,
    input  logic [PORT_W-1:0] in_src_port,
    output idx_stage_t        out_q
);
    idx_stage_t st_d, st_q;
    logic [IDX_W-1:0] flood_idx;

    always_comb begin
        case (in_class)
            CLS_UCAST:           flood_idx = IDX_W'(FLOOD_UC);
            CLS_BCAST, CLS_MCAST: flood_idx = IDX_W'(FLOOD_MC);
            CLS_IPV4:            flood_idx = IDX_W'(FLOOD_IPV4);
            CLS_IPV6:            flood_idx = IDX_W'(FLOOD_IPV6);
            default:             flood_idx = IDX_W'(FLOOD_MC);
        endcase
    end

    always_comb begin
        st_d       = st_q;
        st_d.valid = in_valid;
        if (in_valid) begin
            st_d.err = (32'(in_src_port) >= NPORTS);
            st_d.dst = in_hit ? IDX_W'(in_dst_idx) : flood_idx;
            st_d.agg = IDX_W'(AGG_BASE) + IDX_W'(in_agg_code);
            st_d.src = st_d.err ? IDX_W'(SRC_BASE)
                                : IDX_W'(SRC_BASE) + IDX_W'(in_src_port);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_q = st_q;

    // R4 R5
    dst_region_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.valid |-> st_q.dst < IDX_W'(AGG_BASE));
    // R6
    agg_region_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.valid |-> (st_q.agg >= IDX_W'(AGG_BASE) && st_q.agg < IDX_W'(SRC_BASE)));
    // R7
    src_region_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.valid |-> (st_q.src >= IDX_W'(SRC_BASE) && 32'(st_q.src) < SRC_BASE + NPORTS));
endmodule

// File: rtl/pgmask_table.sv
module pgmask_table
    import pgmask_pkg::*;
#(
    parameter int NPORTS = 11,
    parameter int MW     = NPORTS + 1,
    parameter int DEPTH  = SRC_BASE + NPORTS
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [MW-1:0]    wr_data,
    input  logic [IDX_W-1:0] rd_a,
    input  logic [IDX_W-1:0] rd_b,
    input  logic [IDX_W-1:0] rd_c,
    output logic [MW-1:0]    q_a,
    output logic [MW-1:0]    q_b,
    output logic [MW-1:0]    q_c
);
    logic [MW-1:0] ent_d [DEPTH];
    logic [MW-1:0] ent_q [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_ent
        always_comb begin
            ent_d[g] = ent_q[g];
            if (wr_en && wr_idx == IDX_W'(g)) ent_d[g] = wr_data;
        end
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) ent_q[g] <= '0;
            else        ent_q[g] <= ent_d[g];
        end
    end

    always_comb begin
        q_a = (32'(rd_a) < DEPTH) ? ent_q[rd_a] : '0;
        q_b = (32'(rd_b) < DEPTH) ? ent_q[rd_b] : '0;
        q_c = (32'(rd_c) < DEPTH) ? ent_q[rd_c] : '0;
    end
endmodule

// File: rtl/pgmask_resolver.sv
module pgmask_resolver
    import pgmask_pkg::*;
#(
    parameter int NPORTS = 11,
    parameter int PORT_W = 4,
    localparam int MW    = NPORTS + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [6:0]        cfg_idx,
    input  logic [MW-1:0]     cfg_data,
    input  logic              req_valid,
    input  logic              req_hit,
    input  logic [5:0]        req_dst_idx,
    input  logic [2:0]        req_class,
    input  logic [3:0]        req_agg_code,
    input  logic [PORT_W-1:0] req_src_port,
    output logic              rsp_valid,
    output logic [MW-1:0]     rsp_mask,
    output logic              rsp_err
);
    typedef struct packed {
        logic          valid;
        logic          err;
        logic [MW-1:0] mask;
    } out_stage_t;

    idx_stage_t    s1;
    logic [MW-1:0] e_dst, e_agg, e_src;
    out_stage_t    o_d, o_q;

    pgmask_index_sel #(.NPORTS(NPORTS), .PORT_W(PORT_W)) u_sel (
        .clk(clk), .rst_n(rst_n),
        .in_valid(req_valid), .in_hit(req_hit), .in_dst_idx(req_dst_idx),
        .in_class(req_class), .in_agg_code(req_agg_code),
        .in_src_port(req_src_port), .out_q(s1)
    );

    pgmask_table #(.NPORTS(NPORTS)) u_tbl (
        .clk(clk), .rst_n(rst_n),
        .wr_en(cfg_we), .wr_idx(cfg_idx), .wr_data(cfg_data),
        .rd_a(s1.dst), .rd_b(s1.agg), .rd_c(s1.src),
        .q_a(e_dst), .q_b(e_agg), .q_c(e_src)
    );

    always_comb begin
        o_d       = o_q;
        o_d.valid = s1.valid;
        o_d.err   = s1.valid & s1.err;
        if (s1.valid) o_d.mask = s1.err ? '0 : (e_dst & e_agg & e_src);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) o_q <= '0;
        else        o_q <= o_d;
    end

    assign rsp_valid = o_q.valid;
    assign rsp_mask  = o_q.mask;
    assign rsp_err   = o_q.err;

    // R2
    latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(req_valid, 2) |-> rsp_valid);
    // R2
    no_orphan_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rsp_valid) |-> $past(req_valid, 2));
    // R7
    err_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_err |-> (rsp_valid && rsp_mask == '0));
    // R7
    err_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && 32'(req_src_port) >= NPORTS) |=> ##1 rsp_err);
endmodule

// File: tb/test_pgmask_resolver.sv
module test_pgmask_resolver;
    localparam int N  = 11;
    localparam int MW = N + 1;
    localparam int DEPTH = 80 + N;

    logic clk = 0, rst_n = 0;
    logic cfg_we = 0; logic [6:0] cfg_idx = 0; logic [MW-1:0] cfg_data = 0;
    logic req_valid = 0, req_hit = 0; logic [5:0] req_dst_idx = 0;
    logic [2:0] req_class = 0; logic [3:0] req_agg_code = 0; logic [3:0] req_src_port = 0;
    logic rsp_valid, rsp_err; logic [MW-1:0] rsp_mask;

    logic [MW-1:0] model [DEPTH];
    int n_run = 0, n_fail = 0;

    always #10 clk = ~clk;

    pgmask_resolver #(.NPORTS(N), .PORT_W(4)) i_pgmask_resolver (.*);

    initial begin
        #4000000;
        n_fail++;
        $display("FAIL watchdog: run did not complete (got hang, expected finish)");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    function automatic int flood_of(input int cls);
        case (cls) 0: return 60; 1, 2: return 61; 3: return 62; 4: return 63; default: return 61; endcase
    endfunction

    function automatic logic [MW:0] expect_res(input bit hit, input int d, input int cls,
                                               input int agg, input int src);
        int di;
        if (src >= N) return {1'b1, {MW{1'b0}}};
        di = hit ? d : flood_of(cls);
        return {1'b0, model[di] & model[64 + agg] & model[80 + src]};
    endfunction

    task automatic cfg_write(input int idx, input logic [MW-1:0] v);
        @(negedge clk); cfg_we = 1; cfg_idx = 7'(idx); cfg_data = v;
        @(negedge clk); cfg_we = 0;
        if (idx < DEPTH) model[idx] = v;
    endtask

    task automatic check(input string req, input bit hit, input int d, input int cls,
                         input int agg, input int src);
        logic [MW:0] e;
        e = expect_res(hit, d, cls, agg, src);
        @(negedge clk);
        req_valid = 1; req_hit = hit; req_dst_idx = 6'(d); req_class = 3'(cls);
        req_agg_code = 4'(agg); req_src_port = 4'(src);
        @(negedge clk); req_valid = 0;
        @(negedge clk);
        n_run++;
        if (!rsp_valid || rsp_err !== e[MW] || rsp_mask !== e[MW-1:0]) begin
            n_fail++;
            $display("FAIL %s: got v=%b err=%b mask=%h, expected v=1 err=%b mask=%h",
                     req, rsp_valid, rsp_err, rsp_mask, e[MW], e[MW-1:0]);
        end
    endtask

    initial begin
        int seed;
        logic [MW:0] e;
        seed = 32'h5eed;
        void'($urandom(seed));
        for (int i = 0; i < DEPTH; i++) model[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1: everything zero after reset
        @(negedge clk); n_run++;
        if (rsp_valid !== 0) begin n_fail++; $display("FAIL R1: rsp_valid=%b expected 0", rsp_valid); end
        for (int i = 0; i < DEPTH; i++) model[i] = '1;
        for (int i = 0; i < DEPTH; i++) model[i] = '0;
        check("R1", 1, 5, 0, 0, 0);

        // fill table
        for (int i = 0; i < DEPTH; i++) cfg_write(i, MW'($urandom));
        for (int a = 0; a < 16; a++) cfg_write(64 + a, '1);
        for (int s = 0; s < N; s++) cfg_write(80 + s, '1);
        // R4: hit, direct index incl. CPU entry 59
        cfg_write(59, MW'(1) << N);
        check("R4", 1, 59, 0, 0, 0);
        if (rsp_mask !== (MW'(1) << N)) begin n_fail++; $display("FAIL R3: cpu bit got %h expected %h", rsp_mask, MW'(1) << N); end
        n_run++;
        check("R4", 1, 3, 2, 1, 1);
        // R5: floods, distinct entries, dst_idx ignored
        cfg_write(60, 12'h001); cfg_write(61, 12'h002); cfg_write(62, 12'h004); cfg_write(63, 12'h008);
        for (int c = 0; c < 5; c++) check("R5", 0, 7, c, 0, 0);
        // R6: aggregation selection
        for (int a = 0; a < 16; a++) cfg_write(64 + a, MW'(1) << (a % N));
        cfg_write(61, '1);
        for (int a = 0; a < 16; a++) check("R6", 0, 0, 1, a, 2);
        // R7: source restriction and out of range
        cfg_write(80 + 4, 12'h0F0);
        check("R7", 0, 0, 1, 5, 4);
        check("R7", 0, 0, 1, 4, 4);
        check("R7", 0, 0, 1, 0, N);
        check("R7", 0, 0, 1, 0, 15);
        // R8: write beyond table has no effect
        cfg_write(100, '1); cfg_write(127, '1);
        check("R8", 0, 0, 1, 3, 4);
        // R8: same-cycle write returns old value
        e = expect_res(1, 10, 0, 0, 0);
        cfg_write(64, '1); cfg_write(80, '1);
        e = expect_res(1, 10, 0, 0, 0);
        @(negedge clk);
        req_valid = 1; req_hit = 1; req_dst_idx = 10; req_class = 0; req_agg_code = 0; req_src_port = 0;
        @(negedge clk); req_valid = 0; cfg_we = 1; cfg_idx = 10; cfg_data = ~model[10];
        @(negedge clk); cfg_we = 0; n_run++;
        if (!rsp_valid || rsp_mask !== e[MW-1:0]) begin
            n_fail++; $display("FAIL R8: got %h expected old %h", rsp_mask, e[MW-1:0]);
        end
        model[10] = ~model[10];
        check("R8", 1, 10, 0, 0, 0);
        // R2: back-to-back stream order
        begin
            logic [MW:0] q [4];
            for (int k = 0; k < 4; k++) q[k] = expect_res(1, k, 0, 0, k);
            @(negedge clk);
            for (int k = 0; k < 4; k++) begin
                req_valid = 1; req_hit = 1; req_dst_idx = 6'(k); req_agg_code = 0; req_src_port = 4'(k);
                @(negedge clk);
                if (k >= 1) begin
                    n_run++;
                    if (!rsp_valid || rsp_mask !== q[k-1][MW-1:0]) begin
                        n_fail++; $display("FAIL R2: beat %0d got %h expected %h", k-1, rsp_mask, q[k-1][MW-1:0]);
                    end
                end
            end
            req_valid = 0;
            @(negedge clk); n_run++;
            if (!rsp_valid || rsp_mask !== q[3][MW-1:0]) begin
                n_fail++; $display("FAIL R2: beat 3 got %h expected %h", rsp_mask, q[3][MW-1:0]);
            end
        end
        // R3: random mix
        for (int i = 0; i < 20; i++) cfg_write($urandom % DEPTH, MW'($urandom));
        for (int i = 0; i < 200; i++)
            check("R3", 1'($urandom), $urandom % 64, $urandom % 5, $urandom % 16, $urandom % 13);
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule